// File: doc/BRIEF.md
# ISDN B-Channel Path Conditioner

This block conditions the 2B+D data that moves between a serial frame interface and the transmit and receive sides of an S/T line transceiver. Each frame arrives as one 18-bit word: bits [17:10] are B1, bits [9:2] are B2 and bits [1:0] are D. A one-cycle frame strobe marks each frame. On every strobe the block produces one conditioned word for the line and one word back to the frame interface. These words are valid one cycle after the strobe.

For each B channel the block can force the all-ones idle pattern, gate the channel on or off, and invert the data in both directions. The meaning of the channel control bit depends on a static side-select input. On the network side a set bit idles the channel. On the terminal side a set bit enables it. Every control bit clears on reset, so a terminal-side device starts with its B channels idle and a network-side device starts with data passing. A swap bit exchanges the two B timeslots. A loopback bit returns the captured frame-interface word one frame later, and the line side does not see any change.

Control sits in two 4-bit registers. They are written synchronously and read back combinationally over a simple bus with a one-bit address.

Top module: `bch_cond`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, every control bit reads 0, `out_valid` is 0 and both output words are 0.
- R2: A one-cycle `sw_rst` clears every control bit on the next clock edge. If a register write occurs in the same cycle, `sw_rst` takes precedence.
- R3: Register 0 (`reg_addr`=0) holds [3]=B1 channel control, [2]=B2 channel control, [1]=B1 invert and [0]=B2 invert. Register 1 holds [3]=loopback and [2]=swap, and its bits [1:0] always read 0. A write takes effect on the clock edge. `rd_data` shows the addressed register in the same cycle.
- R4: `out_valid` is high for exactly the one cycle after each `fr_strobe` cycle. Both output words change only on the edge that samples a strobe.
- R5: On the network side (`mode_nt`=1), a channel control bit of 1 puts 0xFF on that channel's line timeslot. A bit of 0 passes the frame-interface data.
- R6: On the terminal side (`mode_nt`=0), a channel control bit of 0 puts 0xFF on that channel's line timeslot. A bit of 1 passes the data. Because of this, after reset both B timeslots idle.
- R7: An invert bit complements that channel's frame-interface data before it goes to the line. Idle forcing overrides inversion.
- R8: An invert bit complements the line data of that channel before it goes to `fr_tx_word`.
- R9: With swap set, the line B1 timeslot carries the conditioned B2 channel and the line B2 timeslot carries the conditioned B1 channel. In the receive direction, line B2 feeds frame B1 and line B1 feeds frame B2, and each is inverted by its frame channel's invert bit.
- R10: The D bits pass unchanged in both directions.
- R11: With loopback set, `fr_tx_word` equals the `fr_rx_word` captured at the previous strobe, unmodified. The capture runs on every strobe whether or not loopback is set.
- R12: Loopback does not change `line_tx_word`; the line still gets the normally conditioned frame data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset of the control bits |
| mode_nt | input | 1 | Static side select: 1 network side, 0 terminal side |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Read-back of the addressed register |
| fr_strobe | input | 1 | One-cycle frame boundary pulse |
| fr_rx_word | input | 18 | Frame-interface word toward the line |
| line_rx_word | input | 18 | Line word received from the transceiver |
| line_tx_word | output | 18 | Conditioned word to the transmitter |
| fr_tx_word | output | 18 | Word returned to the frame interface |
| out_valid | output | 1 | High the cycle after a strobe |

## Verification
The assertions assume that `fr_strobe` is one cycle wide. They also assume that `mode_nt` and the frame words stay stable in the cycle the strobe is sampled. The idle, D-channel and loopback properties are checked against the configuration that was present when the strobe was sampled. The stimulus changes `mode_nt` only between frames and never makes a register write in the same cycle as a strobe. It spaces strobes at least two cycles apart, so each result is compared before the next frame arrives.

// File: rtl/bch_pkg.sv
package bch_pkg;
    localparam int B_BITS = 8;
    localparam int D_BITS = 2;
    localparam int CREG_W = 4;

    typedef struct packed {
        logic ctl_b1;
        logic ctl_b2;
        logic inv_b1;
        logic inv_b2;
        logic loop_en;
        logic swap_en;
    } cfg_t;
endpackage

// File: rtl/bch_cfg_regs.sv
module bch_cfg_regs
    import bch_pkg::*;
#(
    parameter int REG_W = CREG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sw_rst) begin
            cfg_d = '0;
        end else if (wr_en) begin
            if (!addr) begin
                {cfg_d.ctl_b1, cfg_d.ctl_b2, cfg_d.inv_b1, cfg_d.inv_b2} = wdata[REG_W-1 -: 4];
            end else begin
                {cfg_d.loop_en, cfg_d.swap_en} = wdata[REG_W-1 -: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (!addr) rdata[REG_W-1 -: 4] = {cfg_q.ctl_b1, cfg_q.ctl_b2, cfg_q.inv_b1, cfg_q.inv_b2};
        else       rdata[REG_W-1 -: 2] = {cfg_q.loop_en, cfg_q.swap_en};
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bch_tx_path.sv
module bch_tx_path
    import bch_pkg::*;
#(
    parameter int BW = B_BITS,
    parameter int DW = D_BITS,
    localparam int FW = 2 * BW + DW
) (
    input  logic          mode_nt,
    input  cfg_t          cfg,
    input  logic [FW-1:0] fr_word,
    output logic [FW-1:0] line_word
);
    logic [1:0]    ctl, inv, idle;
    logic [BW-1:0] chan_in  [2];
    logic [BW-1:0] chan_out [2];

    assign ctl = {cfg.ctl_b2, cfg.ctl_b1};
    assign inv = {cfg.inv_b2, cfg.inv_b1};
    assign chan_in[0] = fr_word[FW-1 -: BW];
    assign chan_in[1] = fr_word[DW +: BW];

    for (genvar c = 0; c < 2; c++) begin : g_chan
        // channel gate first; forced idle wins over inversion
        assign idle[c] = mode_nt ? ctl[c] : ~ctl[c];
        always_comb begin
            if (idle[c])     chan_out[c] = '1;
            else if (inv[c]) chan_out[c] = ~chan_in[c];
            else             chan_out[c] = chan_in[c];
        end
    end

    always_comb begin
        if (cfg.swap_en) line_word = {chan_out[1], chan_out[0], fr_word[DW-1:0]};
        else             line_word = {chan_out[0], chan_out[1], fr_word[DW-1:0]};
    end
endmodule

// File: rtl/bch_rx_path.sv
module bch_rx_path
    import bch_pkg::*;
#(
    parameter int BW = B_BITS,
    parameter int DW = D_BITS,
    localparam int FW = 2 * BW + DW
) (
    input  cfg_t          cfg,
    input  logic [FW-1:0] line_word,
    output logic [FW-1:0] fr_word
);
    logic [1:0]    inv;
    logic [BW-1:0] slot [2];
    logic [BW-1:0] chan [2];

    assign inv     = {cfg.inv_b2, cfg.inv_b1};
    assign slot[0] = line_word[FW-1 -: BW];
    assign slot[1] = line_word[DW +: BW];

    for (genvar c = 0; c < 2; c++) begin : g_chan
        logic [BW-1:0] src;
        assign src     = cfg.swap_en ? slot[1-c] : slot[c];
        assign chan[c] = inv[c] ? ~src : src;
    end

    assign fr_word = {chan[0], chan[1], line_word[DW-1:0]};
endmodule

// File: rtl/bch_cond.sv
module bch_cond
    import bch_pkg::*;
#(
    parameter int BW    = B_BITS,
    parameter int DW    = D_BITS,
    parameter int REG_W = CREG_W,
    localparam int FW   = 2 * BW + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             mode_nt,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             fr_strobe,
    input  logic [FW-1:0]    fr_rx_word,
    input  logic [FW-1:0]    line_rx_word,
    output logic [FW-1:0]    line_tx_word,
    output logic [FW-1:0]    fr_tx_word,
    output logic             out_valid
);
    typedef struct packed {
        logic [FW-1:0] line_tx;
        logic [FW-1:0] fr_tx;
        logic [FW-1:0] lb_buf;
        logic          valid;
    } path_t;

    cfg_t          cfg;
    logic [FW-1:0] tx_cond, rx_cond;
    path_t         st_d, st_q;

    bch_cfg_regs #(.REG_W(REG_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_rst(sw_rst),
        .wr_en (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    bch_tx_path #(.BW(BW), .DW(DW)) u_tx (
        .mode_nt  (mode_nt),
        .cfg      (cfg),
        .fr_word  (fr_rx_word),
        .line_word(tx_cond)
    );

    bch_rx_path #(.BW(BW), .DW(DW)) u_rx (
        .cfg      (cfg),
        .line_word(line_rx_word),
        .fr_word  (rx_cond)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = fr_strobe;
        if (fr_strobe) begin
            st_d.line_tx = tx_cond;
            st_d.fr_tx   = cfg.loop_en ? st_q.lb_buf : rx_cond;
            st_d.lb_buf  = fr_rx_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_tx_word = st_q.line_tx;
    assign fr_tx_word   = st_q.fr_tx;
    assign out_valid    = st_q.valid;
endmodule

// File: rtl/bch_cond_chk.sv
module bch_cond_chk
    import bch_pkg::*;
#(
    parameter int BW = B_BITS,
    parameter int DW = D_BITS,
    localparam int FW = 2 * BW + DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sw_rst,
    input logic          mode_nt,
    input logic          fr_strobe,
    input logic [FW-1:0] fr_rx_word,
    input logic [FW-1:0] line_tx_word,
    input logic [FW-1:0] fr_tx_word,
    input logic          out_valid,
    input cfg_t          cfg
);
    logic [FW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_q <= '0;
        else if (fr_strobe) seen_q <= fr_rx_word;
    end

    p_valid_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fr_strobe |=> out_valid);
    p_valid_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_strobe |=> !out_valid);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_strobe |=> ($stable(line_tx_word) && $stable(fr_tx_word)));
    p_swrst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (cfg == '0));
    p_d_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_strobe |=> (line_tx_word[DW-1:0] == $past(fr_rx_word[DW-1:0])));
    p_te_idle_b1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_strobe && !mode_nt && !cfg.ctl_b1 && !cfg.swap_en)
        |=> (line_tx_word[FW-1 -: BW] == '1));
    p_nt_idle_b2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_strobe && mode_nt && cfg.ctl_b2 && !cfg.swap_en)
        |=> (line_tx_word[DW +: BW] == '1));
    p_loop_ret_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_strobe && cfg.loop_en) |=> (fr_tx_word == $past(seen_q)));
endmodule

bind bch_cond bch_cond_chk #(.BW(BW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .mode_nt     (mode_nt),
    .fr_strobe   (fr_strobe),
    .fr_rx_word  (fr_rx_word),
    .line_tx_word(line_tx_word),
    .fr_tx_word  (fr_tx_word),
    .out_valid   (out_valid),
    .cfg         (cfg)
);

// File: tb/bch_cond_tb.sv
module bch_cond_tb_top;
    localparam int FW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0;
    logic          mode_nt = 1'b0;
    logic          reg_we = 1'b0;
    logic          reg_addr = 1'b0;
    logic [3:0]    reg_wdata = '0;
    logic [3:0]    reg_rdata;
    logic          fr_strobe = 1'b0;
    logic [FW-1:0] fr_rx_word = '0;
    logic [FW-1:0] line_rx_word = '0;
    logic [FW-1:0] line_tx_word;
    logic [FW-1:0] fr_tx_word;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench copy of the control bits
    bit m_ctl1, m_ctl2, m_inv1, m_inv2, m_loop, m_swap;
    logic [FW-1:0] m_prev = '0;

    typedef struct packed {
        logic [FW-1:0] line;
        logic [FW-1:0] fr;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    bch_cond dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode_nt(mode_nt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fr_strobe(fr_strobe), .fr_rx_word(fr_rx_word),
        .line_rx_word(line_rx_word), .line_tx_word(line_tx_word),
        .fr_tx_word(fr_tx_word), .out_valid(out_valid)
    );

    task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [FW-1:0] model_line(input logic [FW-1:0] f);
        logic [7:0] c1, c2;
        bit idle1, idle2;
        idle1 = mode_nt ? m_ctl1 : !m_ctl1;
        idle2 = mode_nt ? m_ctl2 : !m_ctl2;
        c1 = idle1 ? 8'hFF : (m_inv1 ? ~f[17:10] : f[17:10]);
        c2 = idle2 ? 8'hFF : (m_inv2 ? ~f[9:2] : f[9:2]);
        return m_swap ? {c2, c1, f[1:0]} : {c1, c2, f[1:0]};
    endfunction

    function automatic logic [FW-1:0] model_fr(input logic [FW-1:0] l);
        logic [7:0] s1, s2;
        if (m_loop) return m_prev;
        s1 = m_swap ? l[9:2] : l[17:10];
        s2 = m_swap ? l[17:10] : l[9:2];
        if (m_inv1) s1 = ~s1;
        if (m_inv2) s2 = ~s2;
        return {s1, s2, l[1:0]};
    endfunction

    task automatic wr(input bit a, input logic [3:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (!a) {m_ctl1, m_ctl2, m_inv1, m_inv2} = d;
        else    {m_loop, m_swap} = d[3:2];
    endtask

    task automatic rd_check(input bit a, input logic [3:0] expv, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {14'd0, reg_rdata}, {14'd0, expv});
    endtask

    task automatic frame(input logic [FW-1:0] f, input logic [FW-1:0] l, input string tag);
        exp_t e;
        @(negedge clk);
        fr_strobe = 1'b1; fr_rx_word = f; line_rx_word = l;
        e.line = model_line(f);
        e.fr   = model_fr(l);
        m_prev = f;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        fr_strobe = 1'b0;
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " line"}, line_tx_word, e.line);
                check({t, " frame"}, fr_tx_word, e.fr);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 valid", {17'd0, out_valid}, '0);
        check("R1 line", line_tx_word, '0);
        check("R1 frame", fr_tx_word, '0);
        rd_check(1'b0, 4'h0, "R1 reg0");
        rd_check(1'b1, 4'h0, "R1 reg1");

        // R6 terminal side: reset leaves B channels idle
        mode_nt = 1'b0;
        frame({8'hA5, 8'h3C, 2'b10}, {8'h12, 8'h34, 2'b01}, "R6 te idle after reset");
        wr(1'b0, 4'b1100);
        rd_check(1'b0, 4'b1100, "R3 reg0 readback");
        frame({8'hA5, 8'h3C, 2'b10}, {8'h12, 8'h34, 2'b01}, "R6 te enabled R10");
        // R7 R8 inversion both directions
        wr(1'b0, 4'b1111);
        frame({8'h0F, 8'hF0, 2'b11}, {8'h55, 8'h81, 2'b00}, "R7 R8 invert");
        // R7 idle overrides inversion on B1
        wr(1'b0, 4'b0111);
        frame({8'h00, 8'h66, 2'b01}, {8'h77, 8'h88, 2'b10}, "R7 idle over invert");

        // R5 network side
        mode_nt = 1'b1;
        wr(1'b0, 4'b0000);
        frame({8'hC3, 8'h5A, 2'b00}, {8'h9E, 8'h01, 2'b11}, "R5 nt pass after reset value");
        wr(1'b0, 4'b0100);
        frame({8'hC3, 8'h5A, 2'b01}, {8'h9E, 8'h01, 2'b11}, "R5 nt idle b2");
        wr(1'b0, 4'b1000);
        frame({8'h11, 8'h22, 2'b10}, {8'h33, 8'h44, 2'b01}, "R5 nt idle b1");

        // R9 swap, with B1 inverted and B2 idled
        wr(1'b0, 4'b0110);
        wr(1'b1, 4'b0100);
        rd_check(1'b1, 4'b0100, "R3 reg1 readback");
        frame({8'h3A, 8'hC5, 2'b11}, {8'hE1, 8'h1E, 2'b10}, "R9 swap");
        wr(1'b0, 4'b0001);
        frame({8'h80, 8'h01, 2'b00}, {8'hF0, 8'h0F, 2'b01}, "R9 swap inv b2");

        // R11 R12 loopback, transparent toward line
        wr(1'b1, 4'b1000);
        frame({8'hDE, 8'hAD, 2'b10}, {8'hBE, 8'hEF, 2'b01}, "R11 R12 loop first");
        frame({8'h12, 8'h48, 2'b01}, {8'h00, 8'hFF, 2'b11}, "R11 R12 loop second");
        wr(1'b1, 4'b0000);
        frame({8'h5C, 8'hC5, 2'b00}, {8'h24, 8'h42, 2'b10}, "R11 loop off");

        // R3 reserved bits of reg1 read as 0
        wr(1'b1, 4'b1111);
        rd_check(1'b1, 4'b1100, "R3 reg1 reserved zero");
        wr(1'b1, 4'b0000);

        // R4 outputs hold without a strobe
        held = line_tx_word;
        @(negedge clk);
        fr_rx_word = ~fr_rx_word; line_rx_word = ~line_rx_word;
        repeat (3) @(negedge clk);
        check("R4 hold line", line_tx_word, held);
        check("R4 no valid", {17'd0, out_valid}, '0);

        // R2 software reset beats a simultaneous write
        wr(1'b0, 4'b1111);
        @(negedge clk);
        sw_rst = 1'b1; reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 4'b1010;
        @(negedge clk);
        sw_rst = 1'b0; reg_we = 1'b0;
        {m_ctl1, m_ctl2, m_inv1, m_inv2, m_loop, m_swap} = '0;
        rd_check(1'b0, 4'h0, "R2 reg0 cleared");
        rd_check(1'b1, 4'h0, "R2 reg1 cleared");
        mode_nt = 1'b0;
        frame({8'h6B, 8'hB6, 2'b11}, {8'h13, 8'h31, 2'b00}, "R2 R6 te idle after sw reset");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R4 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule